// File: doc/BRIEF.md
# Skew-Tolerant I2C Bus Monitor

This block listens to a two-wire I2C bus without driving it. SCL and SDA are sampled by a fast system clock through a two-stage synchronizer. The block decodes bus conditions and data bytes and reports each one as a single-cycle pulse. It accepts SDA edges that land a few sample clocks away from an SCL edge, because the driving controller may place both edges in the same port write with some jitter between them. Such an edge counts as simultaneous with the SCL edge and raises a detection flag. It is never decoded as a false START or STOP.

An edge classifier has three states. In Idle it watches both lines. An SCL rising edge moves it to Sample, which waits out the skew window and then commits a data bit. An SDA edge while SCL is high moves it to Condition, which waits out the window and then commits START or STOP. If SCL falls before the window ends, it returns to Idle and raises the falling-edge flag instead. A frame state machine also has three states. A START moves it from Free to Data. The eighth data bit moves it from Data to Ack. The ACK bit moves it back to Data. A STOP returns it to Free from either Data or Ack. A START in Data or Ack reports a repeated START and restarts the byte. An enabled detection during a frame puts the block in bit mode. It stays there until the byte closes.

Top module: `i2c_skew_monitor`

## Requirements
- R1: After reset, with both lines held high, all event outputs stay low and `bit_mode_o` is low.
- R2: A falling SDA edge while SCL is high gives `start_o`, and a rising one gives `stop_o`, provided the edge is more than `skew_win` sample clocks away from any SCL edge.
- R3: Data bits are taken at SCL rising edges, MSB first. After eight bits, the ninth bit is the ACK bit. `byte_valid_o` then pulses with `byte_data_o`, and `byte_ack_o` is 1 when that ninth bit was low.
- R4: A START followed by a STOP with no SCL pulse between them raises no detection flag. `empty_o` pulses together with `stop_o` when `en_empty` is 1.
- R5: An SDA edge within `skew_win` sample clocks of an SCL falling edge is taken as an ordinary data change, never as START or STOP. It pulses `fall_flag_o` when `en_fall` is 1.
- R6: An SDA edge within `skew_win` sample clocks of an SCL rising edge is accepted. The bit takes the value SDA has after the edge, and `rise_flag_o` pulses when `en_rise` is 1.
- R7: `skew_win` sets the window in sample clocks. An SDA change exactly `skew_win` clocks after an SCL rise still counts as coincident. One clock later, the bit keeps the old value and the change is decoded as a bus condition.
- R8: Each of `en_fall`, `en_rise` and `en_empty` acts alone. A disabled detection never pulses its output and does not start bit mode.
- R9: After an enabled fall or rise detection inside a frame, `bit_mode_o` goes high. Each following bit, including the one that carried the detection, pulses `bit_valid_o` with `bit_value_o`. `bit_mode_o` drops when the byte is reported with its ACK.
- R10: A START while a frame is open pulses `rstart_o` and not `start_o`. The partly received byte is dropped, and no `byte_valid_o` follows for it.
- R11: A bus condition and a data bit never appear in the same cycle, and `start_o` never coincides with `stop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| skew_win | input | 8 | Skew window in sample clocks |
| en_fall | input | 1 | Enable SDA-at-SCL-fall detection |
| en_rise | input | 1 | Enable SDA-at-SCL-rise detection |
| en_empty | input | 1 | Enable START-then-STOP report |
| start_o | output | 1 | START from a free bus |
| rstart_o | output | 1 | Repeated START |
| stop_o | output | 1 | STOP |
| empty_o | output | 1 | Frame closed with no bits |
| byte_valid_o | output | 1 | Byte and ACK reported |
| byte_data_o | output | 8 | Byte value |
| byte_ack_o | output | 1 | 1 when the byte was acknowledged |
| bit_valid_o | output | 1 | Single bit reported in bit mode |
| bit_value_o | output | 1 | Reported bit value |
| bit_mode_o | output | 1 | Bit-by-bit reporting active |
| fall_flag_o | output | 1 | SDA edge coincided with SCL fall |
| rise_flag_o | output | 1 | SDA edge coincided with SCL rise |

## Verification
The assertions assume that each SCL phase lasts longer than the skew window. They also assume that `skew_win` and the three enables change only while the bus is idle, so that the classifier never waits on a window that moves under it. The stimulus holds every SCL half period at 20 clocks, places normal SDA changes 10 clocks from either SCL edge, and uses windows of 4 and 8 clocks. Skewed edges are placed at chosen offsets of 0 to `skew_win + 1` clocks. Repeated STARTs and STOPs are driven with the SCL rise that precedes them, so the bench model also counts the bit that this rise commits.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        CL_IDLE,
        CL_SAMPLE,
        CL_COND
    } cl_state_e;

    typedef enum logic [1:0] {
        FR_FREE,
        FR_DATA,
        FR_ACK
    } fr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic bit_ev;
        logic bit_val;
        logic hit_fall;
        logic hit_rise;
    } line_ev_t;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2cm_edge_class.sv
module i2cm_edge_class
    import i2cm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl,
    input  logic          sda,
    input  logic [AW-1:0] win,
    output line_ev_t      ev
);

    cl_state_e     state, state_n;
    logic          scl_q, sda_q;
    logic [AW-1:0] scl_age, sda_age, tmr;
    logic          rhit_q, cdir_q;
    logic          scl_rise, scl_fall, sda_edge;

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign sda_edge = sda ^ sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CL_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        ev      = '0;
        unique case (state)
            CL_IDLE: begin
                if (scl_rise)          state_n = CL_SAMPLE;
                else if (scl_fall)     ev.hit_fall = sda_edge;
                else if (sda_edge && scl) state_n = CL_COND;
                else if (sda_edge)     ev.hit_fall = (scl_age < win);
            end
            CL_SAMPLE: begin
                if (tmr >= win || scl_fall) begin
                    ev.bit_ev   = 1'b1;
                    ev.bit_val  = sda_q;
                    ev.hit_rise = rhit_q;
                    state_n     = (sda_edge && scl && !scl_fall) ? CL_COND : CL_IDLE;
                end
            end
            CL_COND: begin
                if (tmr >= win) begin
                    ev.start = ~cdir_q;
                    ev.stop  = cdir_q;
                    state_n  = CL_IDLE;
                end else if (scl_fall) begin
                    ev.hit_fall = 1'b1;
                    state_n     = CL_IDLE;
                end
            end
            default: state_n = CL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            scl_age <= '1;
            sda_age <= '1;
            tmr     <= '0;
            rhit_q  <= 1'b0;
            cdir_q  <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            if (scl_rise || scl_fall) scl_age <= '0;
            else if (scl_age != '1)   scl_age <= scl_age + 1'b1;
            if (sda_edge)             sda_age <= '0;
            else if (sda_age != '1)   sda_age <= sda_age + 1'b1;
            if (state_n != state)     tmr <= '0;
            else if (tmr != '1)       tmr <= tmr + 1'b1;
            if (state == CL_IDLE && scl_rise)
                rhit_q <= sda_edge || (sda_age < win);
            else if (state == CL_SAMPLE)
                rhit_q <= rhit_q | sda_edge;
            if (state_n == CL_COND && state != CL_COND)
                cdir_q <= sda;
        end
    end

    // R11
    no_bit_with_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev.bit_ev && (ev.start || ev.stop)));

    // R2
    cond_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.start || ev.stop) |-> scl_q);

endmodule

// File: rtl/i2cm_frame_fsm.sv
module i2cm_frame_fsm
    import i2cm_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  line_ev_t        ev,
    input  logic            en_fall,
    input  logic            en_rise,
    input  logic            en_empty,
    output logic            start_o,
    output logic            rstart_o,
    output logic            stop_o,
    output logic            empty_o,
    output logic            byte_valid_o,
    output logic [BITS-1:0] byte_data_o,
    output logic            byte_ack_o,
    output logic            bit_valid_o,
    output logic            bit_value_o,
    output logic            bit_mode_o,
    output logic            fall_flag_o,
    output logic            rise_flag_o
);

    localparam int CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    fr_state_e       state, state_n;
    logic [CW-1:0]   cnt;
    logic [BITS-1:0] shreg;
    logic            seen;
    logic            err;

    assign err = (ev.hit_fall & en_fall) | (ev.hit_rise & en_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_FREE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            FR_FREE: if (ev.start) state_n = FR_DATA;
            FR_DATA: begin
                if (ev.stop)                          state_n = FR_FREE;
                else if (ev.bit_ev && !ev.start && cnt == LAST) state_n = FR_ACK;
            end
            FR_ACK: begin
                if (ev.stop)                      state_n = FR_FREE;
                else if (ev.start || ev.bit_ev)   state_n = FR_DATA;
            end
            default: state_n = FR_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= 1'b0; rstart_o <= 1'b0; stop_o <= 1'b0; empty_o <= 1'b0;
            byte_valid_o <= 1'b0; byte_data_o <= '0; byte_ack_o <= 1'b0;
            bit_valid_o <= 1'b0; bit_value_o <= 1'b0; bit_mode_o <= 1'b0;
            fall_flag_o <= 1'b0; rise_flag_o <= 1'b0;
            cnt <= '0; shreg <= '0; seen <= 1'b0;
        end else begin
            start_o      <= 1'b0;
            rstart_o     <= 1'b0;
            stop_o       <= 1'b0;
            empty_o      <= 1'b0;
            byte_valid_o <= 1'b0;
            bit_valid_o  <= 1'b0;
            fall_flag_o  <= ev.hit_fall & en_fall;
            rise_flag_o  <= ev.hit_rise & en_rise;
            if (ev.start) begin
                start_o    <= (state == FR_FREE);
                rstart_o   <= (state != FR_FREE);
                cnt        <= '0;
                seen       <= 1'b0;
                bit_mode_o <= 1'b0;
            end else if (ev.stop) begin
                stop_o     <= 1'b1;
                empty_o    <= en_empty && (state != FR_FREE) && !seen;
                cnt        <= '0;
                bit_mode_o <= 1'b0;
            end else if (ev.bit_ev && state != FR_FREE) begin
                seen <= 1'b1;
                if (bit_mode_o || err) begin
                    bit_valid_o <= 1'b1;
                    bit_value_o <= ev.bit_val;
                end
                if (state == FR_ACK) begin
                    byte_valid_o <= 1'b1;
                    byte_data_o  <= shreg;
                    byte_ack_o   <= ~ev.bit_val;
                    bit_mode_o   <= 1'b0;
                    cnt          <= '0;
                end else begin
                    shreg <= {shreg[BITS-2:0], ev.bit_val};
                    cnt   <= cnt + 1'b1;
                    if (err) bit_mode_o <= 1'b1;
                end
            end else if (err && state != FR_FREE) begin
                bit_mode_o <= 1'b1;
            end
        end
    end

    // R3
    byte_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(state == FR_ACK));

    // R4
    empty_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> stop_o);

    // R8
    mode_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_mode_o) |-> (fall_flag_o || rise_flag_o));

    // R9
    bit_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && !byte_valid_o) |-> bit_mode_o);

    // R9
    mode_ends_at_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> !bit_mode_o);

    // R11
    no_start_stop_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((start_o || rstart_o) && stop_o));

endmodule

// File: rtl/i2c_skew_monitor.sv
module i2c_skew_monitor
    import i2cm_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [AW-1:0]   skew_win,
    input  logic            en_fall,
    input  logic            en_rise,
    input  logic            en_empty,
    output logic            start_o,
    output logic            rstart_o,
    output logic            stop_o,
    output logic            empty_o,
    output logic            byte_valid_o,
    output logic [BITS-1:0] byte_data_o,
    output logic            byte_ack_o,
    output logic            bit_valid_o,
    output logic            bit_value_o,
    output logic            bit_mode_o,
    output logic            fall_flag_o,
    output logic            rise_flag_o
);

    logic [1:0] lines_s;
    line_ev_t   ev;

    i2cm_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (lines_s)
    );

    i2cm_edge_class #(.AW(AW)) u_class (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (lines_s[1]),
        .sda   (lines_s[0]),
        .win   (skew_win),
        .ev    (ev)
    );

    i2cm_frame_fsm #(.BITS(BITS)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .en_fall      (en_fall),
        .en_rise      (en_rise),
        .en_empty     (en_empty),
        .start_o      (start_o),
        .rstart_o     (rstart_o),
        .stop_o       (stop_o),
        .empty_o      (empty_o),
        .byte_valid_o (byte_valid_o),
        .byte_data_o  (byte_data_o),
        .byte_ack_o   (byte_ack_o),
        .bit_valid_o  (bit_valid_o),
        .bit_value_o  (bit_value_o),
        .bit_mode_o   (bit_mode_o),
        .fall_flag_o  (fall_flag_o),
        .rise_flag_o  (rise_flag_o)
    );

endmodule

// File: tb/tb_i2c_skew_monitor.sv
module tb_i2c_skew_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int K_FALL = 0, K_RISE = 1, K_START = 2, K_RSTART = 3;
    localparam int K_STOP = 4, K_EMPTY = 5, K_BIT = 6, K_BYTE = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic [7:0] skew_win = 8'd4;
    logic       en_fall = 1'b1, en_rise = 1'b1, en_empty = 1'b1;
    logic       start_o, rstart_o, stop_o, empty_o, byte_valid_o, byte_ack_o;
    logic [7:0] byte_data_o;
    logic       bit_valid_o, bit_value_o, bit_mode_o, fall_flag_o, rise_flag_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_skew_monitor dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .skew_win(skew_win),
        .en_fall(en_fall), .en_rise(en_rise), .en_empty(en_empty),
        .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .empty_o(empty_o),
        .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o), .byte_ack_o(byte_ack_o),
        .bit_valid_o(bit_valid_o), .bit_value_o(bit_value_o), .bit_mode_o(bit_mode_o),
        .fall_flag_o(fall_flag_o), .rise_flag_o(rise_flag_o)
    );

    typedef struct {
        int         kind;
        logic [8:0] data;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;

    // bench model of the frame
    bit         in_frame = 0, bmode = 0, seen = 0;
    int         cnt = 0;
    int         win_m = 4;
    logic [7:0] sh = '0;
    logic       cur = 1'b1;

    task automatic push(int k, logic [8:0] d, string tag);
        item_t it;
        it.kind = k; it.data = d; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic got(int k, logic [8:0] d);
        item_t e;
        n_cmp++;
        if (q.size() == 0) begin
            n_bad++;
            $display("FAIL (unexpected) kind %0d data %0h, expected nothing", k, d);
        end else begin
            e = q.pop_front();
            if (e.kind != k || e.data != d) begin
                n_bad++;
                $display("FAIL %s: kind %0d data %0h, expected kind %0d data %0h",
                         e.tag, k, d, e.kind, e.data);
            end
        end
    endtask

    task automatic chk(logic act, logic exp, string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (fall_flag_o)  got(K_FALL, 9'd0);
            if (rise_flag_o)  got(K_RISE, 9'd0);
            if (start_o)      got(K_START, 9'd0);
            if (rstart_o)     got(K_RSTART, 9'd0);
            if (stop_o)       got(K_STOP, 9'd0);
            if (empty_o)      got(K_EMPTY, 9'd0);
            if (bit_valid_o)  got(K_BIT, {8'd0, bit_value_o});
            if (byte_valid_o) got(K_BYTE, {byte_ack_o, byte_data_o});
        end
    end

    task automatic wn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_bit(logic v, bit rhit, string tag);
        bit err;
        err = rhit && en_rise;
        if (err) push(K_RISE, 9'd0, tag);
        if (in_frame) begin
            seen = 1;
            if (bmode || err) push(K_BIT, {8'd0, v}, tag);
            if (cnt == 8) begin
                push(K_BYTE, {~v, sh}, tag);
                cnt = 0; bmode = 0;
            end else begin
                sh = {sh[6:0], v}; cnt++;
                if (err) bmode = 1;
            end
        end
    endtask

    task automatic m_start(string tag);
        push(in_frame ? K_RSTART : K_START, 9'd0, tag);
        in_frame = 1; cnt = 0; bmode = 0; seen = 0;
    endtask

    task automatic m_stop(string tag);
        push(K_STOP, 9'd0, tag);
        if (in_frame && !seen && en_empty) push(K_EMPTY, 9'd0, tag);
        in_frame = 0; cnt = 0; bmode = 0;
    endtask

    task automatic d_start(string tag);
        if (scl) begin
            wn(10); sda = 1'b0; cur = 1'b0; m_start(tag); wn(20); scl = 1'b0;
        end else begin
            wn(10); sda = 1'b1; cur = 1'b1; wn(10); scl = 1'b1; m_bit(1'b1, 0, tag);
            wn(20); sda = 1'b0; cur = 1'b0; m_start(tag); wn(20); scl = 1'b0;
        end
    endtask

    task automatic d_stop(string tag);
        wn(10); sda = 1'b0; cur = 1'b0; wn(10); scl = 1'b1; m_bit(1'b0, 0, tag);
        wn(20); sda = 1'b1; cur = 1'b1; m_stop(tag); wn(20);
    endtask

    // mode 0 normal, 1 SDA moves d clocks after SCL rise, 2 SDA moves d clocks after SCL fall
    task automatic d_bit(logic v, int mode, int d, string tag);
        if (mode == 2) begin
            wn(d);
            if (cur != v) begin
                if (en_fall) begin
                    push(K_FALL, 9'd0, tag);
                    if (in_frame) bmode = 1;
                end
            end
            sda = v; cur = v; wn(20 - d);
            scl = 1'b1; m_bit(v, 0, tag); wn(20); scl = 1'b0;
        end else if (mode == 1) begin
            wn(10); sda = ~v; cur = ~v; wn(10);
            scl = 1'b1; m_bit(v, d <= win_m, tag);
            wn(d); sda = v; cur = v; wn(20 - d); scl = 1'b0;
        end else begin
            wn(10); sda = v; cur = v; wn(10);
            scl = 1'b1; m_bit(v, 0, tag); wn(20); scl = 1'b0;
        end
    endtask

    task automatic d_byte(logic [7:0] b, logic ackbit, string tag);
        for (int i = 7; i >= 0; i--) d_bit(b[i], 0, 0, tag);
        d_bit(ackbit, 0, 0, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run still busy, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        wn(4);
        rst_n = 1'b1;
        wn(6);
        // R1 reset state with idle bus
        chk(start_o | rstart_o | stop_o | empty_o, 1'b0, "R1 conditions");
        chk(byte_valid_o | bit_valid_o, 1'b0, "R1 data");
        chk(fall_flag_o | rise_flag_o, 1'b0, "R1 flags");
        chk(bit_mode_o, 1'b0, "R1 bit_mode");

        // R2 R3 plain frame, ACK then NACK
        d_start("R2_start");
        d_byte(8'hA5, 1'b0, "R3_ack");
        d_byte(8'h5A, 1'b1, "R3_nack");
        d_stop("R2_stop");

        // R4 START directly followed by STOP, then with report disabled (R8)
        wn(10); sda = 1'b0; cur = 1'b0; m_start("R4_empty"); wn(20);
        sda = 1'b1; cur = 1'b1; m_stop("R4_empty"); wn(20);
        en_empty = 1'b0;
        wn(10); sda = 1'b0; cur = 1'b0; m_start("R8_empty_off"); wn(20);
        sda = 1'b1; cur = 1'b1; m_stop("R8_empty_off"); wn(20);
        en_empty = 1'b1;

        // R6 R9 rise skew mid-byte, R10 repeated START mid-byte
        d_start("R6_frame");
        d_bit(1'b0, 0, 0, "R6_b0");
        d_bit(1'b0, 0, 0, "R6_b1");
        d_bit(1'b1, 1, 2, "R6_skew");
        d_bit(1'b1, 0, 0, "R9_bitmode");
        d_bit(1'b1, 0, 0, "R9_bitmode");
        d_start("R10_rstart");
        d_byte(8'h81, 1'b1, "R10_after");
        d_stop("R10_stop");

        // R5 fall skew, d=1 and d=0
        d_start("R5_frame");
        d_bit(1'b0, 0, 0, "R5_b0");
        d_bit(1'b1, 2, 1, "R5_skew1");
        for (int i = 0; i < 6; i++) d_bit(1'b0, 0, 0, "R9_fallmode");
        d_bit(1'b0, 0, 0, "R9_ack");
        d_bit(1'b1, 2, 0, "R5_skew0");
        d_bit(1'b1, 0, 0, "R5_after");
        d_stop("R5_stop");

        // R8 detections disabled
        en_fall = 1'b0; en_rise = 1'b0;
        d_start("R8_frame");
        d_bit(1'b1, 1, 3, "R8_rise_off");
        d_bit(1'b0, 2, 1, "R8_fall_off");
        d_bit(1'b1, 0, 0, "R8_b");
        d_bit(1'b1, 1, 1, "R8_rise_off");
        for (int i = 0; i < 4; i++) d_bit(1'b0, 0, 0, "R8_b");
        d_bit(1'b0, 0, 0, "R8_ack");
        d_stop("R8_stop");
        en_fall = 1'b1; en_rise = 1'b1;

        // R7 window boundary: d == win coincident, d == win+1 is a condition
        d_start("R7_frame");
        d_bit(1'b0, 1, 4, "R7_edge_in");
        wn(10); sda = 1'b1; cur = 1'b1; wn(10);
        scl = 1'b1; m_bit(1'b1, 0, "R7_late_bit");
        wn(5); sda = 1'b0; cur = 1'b0; m_start("R7_late_rstart");
        wn(15); scl = 1'b0;
        d_byte(8'hC3, 1'b0, "R7_byte");
        d_stop("R7_stop");

        // R7 wider window
        skew_win = 8'd8; win_m = 8;
        wn(10);
        d_start("R7_wide");
        d_bit(1'b1, 1, 6, "R7_wide_skew");
        for (int i = 0; i < 7; i++) d_bit(1'b0, 0, 0, "R7_wide_b");
        d_bit(1'b0, 0, 0, "R7_wide_ack");
        d_stop("R7_wide_stop");

        wn(40);
        while (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            n_cmp++; n_bad++;
            $display("FAIL %s: missing event, got none, expected kind %0d data %0h",
                     e.tag, e.kind, e.data);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule